// File: doc/BRIEF.md
# Indirect Register Write Port

This block is a small window of control registers on a simple write/read bus. Two of its registers act as data ports. A bus write to one of them is passed on to a target that a companion address register selects. The table pair loads entries of a small jump table. The register pair writes into a larger register space through a second output port. In both pairs the address register advances by itself after each forwarded write, so software can stream a run of consecutive values without reloading the address.

The address register of the register-space pair holds two fields. The low half is the target offset and the high half is a flag field. The flags travel with each forwarded write and are never changed by the advance; their meaning belongs to the consumer. Every control write, forwarded or not, also lands in the addressed control register and sets that register's written bit. On newer hardware generations, writes to two particular control registers also clear single bits of a thread-sync register.

Forwarded writes leave through registered write ports. The port pulse and the address update both take effect at the clock edge that accepts the bus write.

Top module: `indirect_wr_port`

## Requirements
- R1: A bus write to the table-data register (index 1) while the table-address register (index 0) holds a value below TBL_DEPTH makes `tbl_we` high for the one cycle after that edge, with `tbl_waddr` equal to the table address and `tbl_wdata` equal to the written value.
- R2: After a forwarded table write, the table-address register holds its previous value plus one.
- R3: A bus write to the table-data register while the table address is TBL_DEPTH or more produces no table write and pulses `tbl_err` for one cycle. The table-address register keeps its value.
- R4: A bus write to the register-data register (index 3) forwards the value on `rsp_wdata`. It places bits [15:0] of the register-address register (index 2) on `rsp_waddr` and bits [31:16] on `rsp_wflags`, with `rsp_we` high for the one cycle after that edge.
- R5: After every register-data write, the offset field [15:0] of the register-address register rises by one and wraps from 0xFFFF to 0. The flag field [31:16] keeps its value.
- R6: If the offset is RSP_DEPTH or more, the register-data write produces no `rsp_we` pulse, but the offset still advances.
- R7: Every bus write stores its value in the addressed control register and sets that register's bit in `ctl_written`. `bus_rdata` returns the register at `bus_raddr` one cycle later.
- R8: While `gen_new` is high, a write to control register 5 clears bit 1 of the thread-sync register (index 4), and a write to register 6 clears its bit 2. While `gen_new` is low, these writes leave the thread-sync register unchanged.
- R9: After reset, all control registers, `ctl_written`, `bus_rdata` and all write-port and error outputs are zero.
- R10: A bus write to any register other than a data register produces no pulse on `tbl_we`, `rsp_we` or `tbl_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_new | input | 1 | Enables the thread-sync side effects |
| bus_we | input | 1 | Control register write strobe |
| bus_waddr | input | $clog2(NREG) | Control register write index |
| bus_wdata | input | 32 | Control register write value |
| bus_raddr | input | $clog2(NREG) | Control register read index |
| bus_rdata | output | 32 | Registered read value |
| ctl_written | output | NREG | One bit per control register, set on write |
| tbl_we | output | 1 | Jump-table write pulse |
| tbl_waddr | output | $clog2(TBL_DEPTH) | Jump-table entry |
| tbl_wdata | output | 32 | Jump-table value |
| tbl_err | output | 1 | Pulse on a dropped out-of-range table write |
| rsp_we | output | 1 | Register-space write pulse |
| rsp_waddr | output | 16 | Register-space offset |
| rsp_wflags | output | 16 | Flag field carried with the write |
| rsp_wdata | output | 32 | Register-space value |

## Verification
The bench builds the block with NREG 16, TBL_DEPTH 8 and RSP_DEPTH 1024. With a table depth of 8, a short stream of table writes walks the address onto the last valid entry and then one past it, so the dropped-write path and its error pulse can be reached. The 1024-entry register space lets a single write stream cross the implemented limit at offset 0x400. Loading the offset 0xFFFF then shows that the offset wraps to zero while a nonzero flag field stays unchanged.

// File: rtl/iwp_pkg.sv
package iwp_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 16;

  typedef struct packed {
    logic              en;
    logic [WORD_W-1:0] val;
  } addr_upd_t;
endpackage

// File: rtl/iwp_ctrl_file.sv
module iwp_ctrl_file
  import iwp_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int IDX_TADDR = 0,
  parameter int IDX_RADDR = 2,
  parameter int IDX_SYNC  = 4,
  localparam int CAW      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [CAW-1:0]    bus_waddr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [CAW-1:0]    bus_raddr,
  input  addr_upd_t         upd_tbl,
  input  addr_upd_t         upd_rsp,
  input  logic [WORD_W-1:0] sync_clr,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NREG-1:0]   written,
  output logic [WORD_W-1:0] taddr_q,
  output logic [WORD_W-1:0] raddr_q,
  output logic [WORD_W-1:0] sync_q
);
  logic [WORD_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      written   <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_we) begin
        regs[bus_waddr]    <= bus_wdata;
        written[bus_waddr] <= 1'b1;
      end
      if (upd_tbl.en) regs[IDX_TADDR] <= upd_tbl.val;
      if (upd_rsp.en) regs[IDX_RADDR] <= upd_rsp.val;
      if (|sync_clr)  regs[IDX_SYNC]  <= regs[IDX_SYNC] & ~sync_clr;
      bus_rdata <= regs[bus_raddr];
    end
  end

  assign taddr_q = regs[IDX_TADDR];
  assign raddr_q = regs[IDX_RADDR];
  assign sync_q  = regs[IDX_SYNC];

  AST_WRITTEN_SET: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> written[$past(bus_waddr)]);  // R7
endmodule

// File: rtl/iwp_tbl_fwd.sv
module iwp_tbl_fwd
  import iwp_pkg::*;
#(
  parameter int TBL_DEPTH = 8,
  localparam int TAW      = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [WORD_W-1:0] data,
  input  logic [WORD_W-1:0] addr_q,
  output addr_upd_t         upd,
  output logic              tbl_we,
  output logic [TAW-1:0]    tbl_waddr,
  output logic [WORD_W-1:0] tbl_wdata,
  output logic              tbl_err
);
  logic in_range;

  assign in_range = addr_q < WORD_W'(TBL_DEPTH);

  always_comb begin
    upd.en  = trig && in_range;
    upd.val = addr_q + WORD_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_we    <= 1'b0;
      tbl_waddr <= '0;
      tbl_wdata <= '0;
      tbl_err   <= 1'b0;
    end else begin
      tbl_we  <= trig && in_range;
      tbl_err <= trig && !in_range;
      if (trig && in_range) begin
        tbl_waddr <= addr_q[TAW-1:0];
        tbl_wdata <= data;
      end
    end
  end

  AST_TBL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(tbl_we && tbl_err));  // R3
endmodule

// File: rtl/iwp_rsp_fwd.sv
module iwp_rsp_fwd
  import iwp_pkg::*;
#(
  parameter int RSP_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [WORD_W-1:0] data,
  input  logic [WORD_W-1:0] addr_q,
  output addr_upd_t         upd,
  output logic              rsp_we,
  output logic [OFF_W-1:0]  rsp_waddr,
  output logic [OFF_W-1:0]  rsp_wflags,
  output logic [WORD_W-1:0] rsp_wdata
);
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] flags;
  logic             in_range;

  assign off      = addr_q[OFF_W-1:0];
  assign flags    = addr_q[WORD_W-1:OFF_W];
  assign in_range = WORD_W'(off) < WORD_W'(RSP_DEPTH);

  always_comb begin
    upd.en  = trig;
    upd.val = {flags, off + OFF_W'(1)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_we     <= 1'b0;
      rsp_waddr  <= '0;
      rsp_wflags <= '0;
      rsp_wdata  <= '0;
    end else begin
      rsp_we <= trig && in_range;
      if (trig && in_range) begin
        rsp_waddr  <= off;
        rsp_wflags <= flags;
        rsp_wdata  <= data;
      end
    end
  end

  AST_RSP_RANGE: assert property (@(posedge clk) disable iff (rst)
    rsp_we |-> WORD_W'(rsp_waddr) < WORD_W'(RSP_DEPTH));  // R6
endmodule

// File: rtl/indirect_wr_port.sv
module indirect_wr_port
  import iwp_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int TBL_DEPTH = 8,
  parameter int RSP_DEPTH = 1024,
  parameter int IDX_TADDR = 0,
  parameter int IDX_TDATA = 1,
  parameter int IDX_RADDR = 2,
  parameter int IDX_RDATA = 3,
  parameter int IDX_SYNC  = 4,
  parameter int IDX_CLR1  = 5,
  parameter int IDX_CLR2  = 6,
  localparam int CAW      = $clog2(NREG),
  localparam int TAW      = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_new,
  input  logic              bus_we,
  input  logic [CAW-1:0]    bus_waddr,
  input  logic [31:0]       bus_wdata,
  input  logic [CAW-1:0]    bus_raddr,
  output logic [31:0]       bus_rdata,
  output logic [NREG-1:0]   ctl_written,
  output logic              tbl_we,
  output logic [TAW-1:0]    tbl_waddr,
  output logic [31:0]       tbl_wdata,
  output logic              tbl_err,
  output logic              rsp_we,
  output logic [15:0]       rsp_waddr,
  output logic [15:0]       rsp_wflags,
  output logic [31:0]       rsp_wdata
);
  addr_upd_t         upd_tbl, upd_rsp;
  logic [WORD_W-1:0] taddr_q, raddr_q, sync_q, sync_clr;
  logic              trig_tbl, trig_rsp;

  assign trig_tbl = bus_we && (bus_waddr == CAW'(IDX_TDATA));
  assign trig_rsp = bus_we && (bus_waddr == CAW'(IDX_RDATA));

  always_comb begin
    sync_clr = '0;
    if (gen_new && bus_we && bus_waddr == CAW'(IDX_CLR1)) sync_clr[1] = 1'b1;
    if (gen_new && bus_we && bus_waddr == CAW'(IDX_CLR2)) sync_clr[2] = 1'b1;
  end

  iwp_ctrl_file #(
    .NREG(NREG), .IDX_TADDR(IDX_TADDR), .IDX_RADDR(IDX_RADDR), .IDX_SYNC(IDX_SYNC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .upd_tbl(upd_tbl),
    .upd_rsp(upd_rsp), .sync_clr(sync_clr), .bus_rdata(bus_rdata),
    .written(ctl_written), .taddr_q(taddr_q), .raddr_q(raddr_q), .sync_q(sync_q)
  );

  iwp_tbl_fwd #(.TBL_DEPTH(TBL_DEPTH)) u_tbl (
    .clk(clk), .rst(rst), .trig(trig_tbl), .data(bus_wdata), .addr_q(taddr_q),
    .upd(upd_tbl), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .tbl_err(tbl_err)
  );

  iwp_rsp_fwd #(.RSP_DEPTH(RSP_DEPTH)) u_rsp (
    .clk(clk), .rst(rst), .trig(trig_rsp), .data(bus_wdata), .addr_q(raddr_q),
    .upd(upd_rsp), .rsp_we(rsp_we), .rsp_waddr(rsp_waddr),
    .rsp_wflags(rsp_wflags), .rsp_wdata(rsp_wdata)
  );

  AST_TBL_FWD: assert property (@(posedge clk) disable iff (rst)
    (trig_tbl && taddr_q < 32'(TBL_DEPTH)) |=> tbl_we && tbl_wdata == $past(bus_wdata));  // R1
  AST_TBL_ADDR_INC: assert property (@(posedge clk) disable iff (rst)
    (trig_tbl && taddr_q < 32'(TBL_DEPTH)) |=> taddr_q == $past(taddr_q) + 32'd1);  // R2
  AST_TBL_DROP: assert property (@(posedge clk) disable iff (rst)
    (trig_tbl && taddr_q >= 32'(TBL_DEPTH)) |=> tbl_err && !tbl_we && $stable(taddr_q));  // R3
  AST_RSP_STEP: assert property (@(posedge clk) disable iff (rst)
    trig_rsp |=> raddr_q[31:16] == $past(raddr_q[31:16]) &&
                 raddr_q[15:0] == $past(raddr_q[15:0]) + 16'd1);  // R5
  AST_SYNC_CLR: assert property (@(posedge clk) disable iff (rst)
    (gen_new && bus_we && bus_waddr == CAW'(IDX_CLR1)) |=> !sync_q[1]);  // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !(trig_tbl || trig_rsp) |=> !tbl_we && !tbl_err && !rsp_we);  // R10
endmodule

// File: tb/indirect_wr_port_bench.sv
`timescale 1ns/1ps
module indirect_wr_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gen_new = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;
  logic [15:0] ctl_written;
  logic        tbl_we, tbl_err, rsp_we;
  logic [2:0]  tbl_waddr;
  logic [31:0] tbl_wdata, rsp_wdata;
  logic [15:0] rsp_waddr, rsp_wflags;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  indirect_wr_port u_indirect_wr_port (
    .clk(clk), .rst(rst), .gen_new(gen_new), .bus_we(bus_we),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata), .ctl_written(ctl_written), .tbl_we(tbl_we),
    .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata), .tbl_err(tbl_err),
    .rsp_we(rsp_we), .rsp_waddr(rsp_waddr), .rsp_wflags(rsp_wflags),
    .rsp_wdata(rsp_wdata)
  );

  // vector: {addr[3:0], data[31:0], exp_tbl_we, exp_rsp_we, exp_port_addr[15:0]}
  localparam logic [53:0] VEC [7] = '{
    {4'd0, 32'd6,          1'b0, 1'b0, 16'h0000},  // R10
    {4'd1, 32'hAAAA_0001,  1'b1, 1'b0, 16'h0006},  // R1
    {4'd1, 32'h0000_0002,  1'b1, 1'b0, 16'h0007},  // R1 R2
    {4'd2, 32'h00A5_03FE,  1'b0, 1'b0, 16'h0000},  // R10
    {4'd3, 32'h0000_0011,  1'b0, 1'b1, 16'h03FE},  // R4
    {4'd3, 32'h0000_0022,  1'b0, 1'b1, 16'h03FF},  // R4 R5
    {4'd3, 32'h0000_0033,  1'b0, 1'b0, 16'h0000}   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_raddr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 tbl_we", 32'(tbl_we), 0);
    check("R9 rsp_we", 32'(rsp_we), 0);
    check("R9 tbl_err", 32'(tbl_err), 0);
    check("R9 written", 32'(ctl_written), 0);
    check("R9 rdata", bus_rdata, 0);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][53:50], VEC[i][49:18]);
      check("R1/R10 tbl_we vec", 32'(tbl_we), 32'(VEC[i][17]));
      check("R4/R6 rsp_we vec", 32'(rsp_we), 32'(VEC[i][16]));
      if (VEC[i][17]) begin
        check("R1 tbl_waddr", 32'(tbl_waddr), 32'(VEC[i][15:0]));
        check("R1 tbl_wdata", tbl_wdata, VEC[i][49:18]);
      end
      if (VEC[i][16]) begin
        check("R4 rsp_waddr", 32'(rsp_waddr), 32'(VEC[i][15:0]));
        check("R4 rsp_wflags", 32'(rsp_wflags), 32'h00A5);
        check("R4 rsp_wdata", rsp_wdata, VEC[i][49:18]);
      end
    end

    rd(4'd0, rv); check("R2 table address advanced", rv, 32'd8);

    wr(4'd1, 32'd5);
    check("R3 no table write", 32'(tbl_we), 0);
    check("R3 error pulse", 32'(tbl_err), 1);
    rd(4'd0, rv); check("R3 address held", rv, 32'd8);
    rd(4'd1, rv); check("R7 data stored", rv, 32'd5);
    rd(4'd2, rv); check("R6 offset advanced past ignored write", rv, 32'h00A5_0401);

    wr(4'd2, 32'h1234_0010);
    check("R3 error is one cycle", 32'(tbl_err), 0);
    wr(4'd3, 32'h55);
    check("R4 rsp_we", 32'(rsp_we), 1);
    check("R4 rsp_waddr", 32'(rsp_waddr), 32'h10);
    check("R4 rsp_wflags", 32'(rsp_wflags), 32'h1234);
    check("R4 rsp_wdata", rsp_wdata, 32'h55);
    rd(4'd2, rv); check("R5 offset step flags kept", rv, 32'h1234_0011);

    wr(4'd2, 32'hBEEF_FFFF);
    wr(4'd3, 32'd7);
    check("R6 out of range dropped", 32'(rsp_we), 0);
    rd(4'd2, rv); check("R5 offset wrap flags kept", rv, 32'hBEEF_0000);
    check("R7 written mask", 32'(ctl_written), 32'h000F);

    wr(4'd4, 32'hF);
    gen_new = 1'b1;
    wr(4'd5, 32'd0);
    rd(4'd4, rv); check("R8 bit1 cleared", rv, 32'hD);
    gen_new = 1'b0;
    wr(4'd6, 32'd0);
    rd(4'd4, rv); check("R8 no effect when old gen", rv, 32'hD);
    gen_new = 1'b1;
    wr(4'd6, 32'd0);
    rd(4'd4, rv); check("R8 bit2 cleared", rv, 32'h9);
    check("R10 sync writes not forwarded", 32'({tbl_we, rsp_we, tbl_err}), 0);
    check("R7 written mask after sync", 32'(ctl_written), 32'h007F);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule